// File: doc/BRIEF.md
# Generalised Register Bit Manipulation Unit

This unit carries out the widened flag instructions of a processor core: set a bit, clear a bit, toggle a bit, or test a bit. It works on any of the 32 bits of any register. The register file reads the operand, and the unit returns the updated word together with a write-enable and the number of the register to write back. For test it returns a zero-flag update instead.

The bit index is built from two parts. A 3-bit base number comes from the opcode. A 3-bit extension field is moved up two places, and its two empty low bits are filled with copies of the field's lowest bit. The two parts are then combined by exclusive-or. The target register is the instruction's default register number, exclusive-ored with a 4-bit selection field. With all extension fields at zero, the unit acts on the default register (the status register) at the bit the opcode names. For example, clear-carry acts on bit 0 and clear-interrupt-disable acts on bit 2.

The operation select chooses between clear and set. The alternate bit turns clear into test and set into toggle. Each accepted request gives a registered response one clock later.

Top module: `flagbit_unit`

## Requirements
- R1: `out_idx` equals `{ext, ext[0], ext[0]} XOR {2'b00, base}`. With `ext` = 0, it equals `base`.
- R2: `out_reg` equals `in_dflt XOR in_sel`. With `in_sel` = 0, it equals `in_dflt`.
- R3: When `in_op`=1 and `in_alt`=0 (set), `out_value` is the operand with bit `out_idx` forced to 1, and `out_we`=1.
- R4: When `in_op`=0 and `in_alt`=0 (clear), `out_value` is the operand with bit `out_idx` forced to 0, and `out_we`=1.
- R5: When `in_op`=1 and `in_alt`=1 (toggle), `out_value` is the operand with bit `out_idx` inverted, and `out_we`=1.
- R6: When `in_op`=0 and `in_alt`=1 (test), `out_we`=0 and `out_value` equals the operand unchanged. `out_z_upd`=1, and `out_z`=1 exactly when the tested bit is 0.
- R7: For set, clear and toggle, no bit other than bit `out_idx` differs between `out_value` and the operand.
- R8: `out_z_upd` is 0 for set, clear and toggle.
- R9: The response to a request with `in_valid`=1 appears one clock later with `out_valid`=1. After a synchronous reset, `out_valid`, `out_we` and `out_z_upd` are 0.
- R10: When `in_valid`=0, the next cycle has `out_valid`=0, `out_we`=0 and `out_z_upd`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_op | input | 1 | 1 = set/toggle, 0 = clear/test |
| in_alt | input | 1 | Alternate operation select |
| in_base | input | 3 | Base bit number from the opcode |
| in_ext | input | 3 | Bit-number extension field |
| in_sel | input | 4 | Register selection field |
| in_dflt | input | 4 | Default register number |
| in_value | input | 32 | Operand read from the register file |
| out_valid | output | 1 | Response present |
| out_reg | output | 4 | Target register number |
| out_idx | output | 5 | Computed bit index |
| out_value | output | 32 | Modified word |
| out_we | output | 1 | Write-back enable |
| out_z_upd | output | 1 | Zero-flag update enable |
| out_z | output | 1 | New zero-flag value |

## Verification
All results share one register stage, so every output (`out_reg`, `out_idx`, `out_value`, `out_we`, `out_z_upd`, `out_z`, `out_valid`) is due exactly one rising edge after the request is presented. The bench drives each request on a falling edge and samples the outputs on the next falling edge, halfway after the edge that registers them. It holds the inputs stable until that sample is taken. The sweeps cover every base, extension, operation and alternate combination, and every default and selection pair. The idle-cycle checks are sampled in the same one-edge window.

// File: rtl/flagbit_pkg.sv
package flagbit_pkg;

    localparam int DATA_W = 32;
    localparam int IDX_W  = $clog2(DATA_W);
    localparam int BASE_W = 3;
    localparam int EXT_W  = 3;
    localparam int REG_W  = 4;

    typedef enum logic [1:0] {
        FB_CLEAR  = 2'b00,
        FB_SET    = 2'b01,
        FB_TEST   = 2'b10,
        FB_TOGGLE = 2'b11
    } fb_kind_e;

    // alternate bit in the high position, set/clear choice in the low one
    function automatic fb_kind_e fb_decode(input logic op, input logic alt);
        return fb_kind_e'({alt, op});
    endfunction

    typedef struct packed {
        logic              valid;
        logic [REG_W-1:0]  reg_num;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] value;
        logic              we;
        logic              z_upd;
        logic              z;
    } fb_resp_t;

endpackage

// File: rtl/fb_index.sv
module fb_index #(
    parameter int BASE_W = flagbit_pkg::BASE_W,
    parameter int EXT_W  = flagbit_pkg::EXT_W,
    parameter int IDX_W  = flagbit_pkg::IDX_W
) (
    input  logic [BASE_W-1:0] base,
    input  logic [EXT_W-1:0]  ext,
    output logic [IDX_W-1:0]  idx
);
    localparam int FILL_W = IDX_W - EXT_W;
    localparam int PAD_W  = IDX_W - BASE_W;

    logic [IDX_W-1:0] expanded;
    logic [IDX_W-1:0] base_wide;

    // extension moved up, vacated low bits filled with its lowest bit
    assign expanded  = {ext, {FILL_W{ext[0]}}};
    assign base_wide = {{PAD_W{1'b0}}, base};
    assign idx       = expanded ^ base_wide;
endmodule

// File: rtl/fb_regsel.sv
module fb_regsel #(
    parameter int REG_W = flagbit_pkg::REG_W
) (
    input  logic [REG_W-1:0] dflt,
    input  logic [REG_W-1:0] sel,
    output logic [REG_W-1:0] reg_num
);
    assign reg_num = dflt ^ sel;
endmodule

// File: rtl/fb_alu.sv
module fb_alu
    import flagbit_pkg::*;
#(
    parameter int DW = flagbit_pkg::DATA_W,
    parameter int IW = flagbit_pkg::IDX_W
) (
    input  fb_kind_e        kind,
    input  logic [IW-1:0]   idx,
    input  logic [DW-1:0]   operand,
    output logic [DW-1:0]   result,
    output logic            we,
    output logic            z_upd,
    output logic            z
);
    logic [DW-1:0] hit;

    for (genvar i = 0; i < DW; i++) begin : g_bit
        assign hit[i] = (idx == IW'(i));
        always_comb begin
            unique case (kind)
                FB_SET:    result[i] = operand[i] | hit[i];
                FB_CLEAR:  result[i] = operand[i] & ~hit[i];
                FB_TOGGLE: result[i] = operand[i] ^ hit[i];
                default:   result[i] = operand[i];
            endcase
        end
    end

    assign we    = (kind != FB_TEST);
    assign z_upd = (kind == FB_TEST);
    assign z     = ~operand[idx];
endmodule

// File: rtl/flagbit_unit.sv
module flagbit_unit
    import flagbit_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_op,
    input  logic              in_alt,
    input  logic [BASE_W-1:0] in_base,
    input  logic [EXT_W-1:0]  in_ext,
    input  logic [REG_W-1:0]  in_sel,
    input  logic [REG_W-1:0]  in_dflt,
    input  logic [DATA_W-1:0] in_value,
    output logic              out_valid,
    output logic [REG_W-1:0]  out_reg,
    output logic [IDX_W-1:0]  out_idx,
    output logic [DATA_W-1:0] out_value,
    output logic              out_we,
    output logic              out_z_upd,
    output logic              out_z
);
    fb_kind_e          kind;
    logic [IDX_W-1:0]  idx_c;
    logic [REG_W-1:0]  reg_c;
    logic [DATA_W-1:0] res_c;
    logic              we_c, zu_c, z_c;
    fb_resp_t          nxt, cur;

    assign kind = fb_decode(in_op, in_alt);

    fb_index #(.BASE_W(BASE_W), .EXT_W(EXT_W), .IDX_W(IDX_W)) u_index (
        .base(in_base), .ext(in_ext), .idx(idx_c)
    );

    fb_regsel #(.REG_W(REG_W)) u_regsel (
        .dflt(in_dflt), .sel(in_sel), .reg_num(reg_c)
    );

    fb_alu #(.DW(DATA_W), .IW(IDX_W)) u_alu (
        .kind(kind), .idx(idx_c), .operand(in_value),
        .result(res_c), .we(we_c), .z_upd(zu_c), .z(z_c)
    );

    always_comb begin
        nxt.valid   = in_valid;
        nxt.reg_num = reg_c;
        nxt.idx     = idx_c;
        nxt.value   = res_c;
        nxt.we      = in_valid & we_c;
        nxt.z_upd   = in_valid & zu_c;
        nxt.z       = z_c;
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= nxt;
    end

    assign out_valid = cur.valid;
    assign out_reg   = cur.reg_num;
    assign out_idx   = cur.idx;
    assign out_value = cur.value;
    assign out_we    = cur.we;
    assign out_z_upd = cur.z_upd;
    assign out_z     = cur.z;

    // R9
    latency_one_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_we && !out_z_upd));

    // R6
    test_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_op && in_alt) |=> (!out_we && out_z_upd && out_value == $past(in_value)));

    // R7
    single_bit_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> $countones(out_value ^ $past(in_value)) <= 1);

    // R3
    set_bit_high_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op && !in_alt) |=> (out_we && out_value[out_idx]));

    // R4
    clear_bit_low_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_op && !in_alt) |=> (out_we && !out_value[out_idx]));

    // R8
    z_only_test_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !(!in_op && in_alt)) |=> !out_z_upd);
endmodule

// File: tb/test_flagbit_unit.sv
`timescale 1ns/1ps
module test_flagbit_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, in_op, in_alt;
    logic [2:0]  in_base, in_ext;
    logic [3:0]  in_sel, in_dflt;
    logic [31:0] in_value;
    logic        out_valid, out_we, out_z_upd, out_z;
    logic [3:0]  out_reg;
    logic [4:0]  out_idx;
    logic [31:0] out_value;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    flagbit_unit i_flagbit_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_alt(in_alt),
        .in_base(in_base), .in_ext(in_ext), .in_sel(in_sel), .in_dflt(in_dflt),
        .in_value(in_value), .out_valid(out_valid), .out_reg(out_reg), .out_idx(out_idx),
        .out_value(out_value), .out_we(out_we), .out_z_upd(out_z_upd), .out_z(out_z)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive on a falling edge, sample on the next falling edge
    task automatic issue(input bit v, input bit op, input bit alt, input int b, input int e,
                         input int s, input int d, input logic [31:0] val);
        in_valid = v; in_op = op; in_alt = alt;
        in_base = 3'(b); in_ext = 3'(e); in_sel = 4'(s); in_dflt = 4'(d); in_value = val;
        @(negedge clk);
    endtask

    initial begin
        #(20 * 5000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        in_valid = 0; in_op = 0; in_alt = 0; in_base = 0; in_ext = 0;
        in_sel = 0; in_dflt = 0; in_value = 0;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(!out_valid && !out_we && !out_z_upd, "R9 reset",
            {29'd0, out_valid, out_we, out_z_upd}, 32'd0);
        rst = 1'b0;

        // full sweep of base, extension, op and alternate
        for (int b = 0; b < 8; b++)
        for (int e = 0; e < 8; e++)
        for (int op = 0; op < 2; op++)
        for (int alt = 0; alt < 2; alt++) begin
            logic [31:0] val, expv, mask;
            int ix;
            val  = 32'h9E37_79B9 * (b * 37 + e * 5 + op * 3 + alt + 1);
            ix   = ((e * 4) + ((e % 2) * 3)) ^ b;
            mask = 32'd1 << ix;
            issue(1'b1, op[0], alt[0], b, e, 0, 12, val);
            chk(out_valid, "R9 valid", {31'd0, out_valid}, 32'd1);
            chk(out_idx == 5'(ix), "R1 index", {27'd0, out_idx}, ix);
            if (op == 1 && alt == 0) begin
                expv = val | mask;
                chk(out_value == expv && out_we, "R3 set", out_value, expv);
                chk(!out_z_upd, "R8 set", {31'd0, out_z_upd}, 0);
            end else if (op == 0 && alt == 0) begin
                expv = val & ~mask;
                chk(out_value == expv && out_we, "R4 clear", out_value, expv);
                chk(!out_z_upd, "R8 clear", {31'd0, out_z_upd}, 0);
            end else if (op == 1) begin
                expv = val ^ mask;
                chk(out_value == expv && out_we, "R5 toggle", out_value, expv);
                chk(!out_z_upd, "R8 toggle", {31'd0, out_z_upd}, 0);
            end else begin
                expv = val;
                chk(out_value == expv && !out_we && out_z_upd, "R6 test value",
                    out_value, expv);
                chk(out_z == ((val & mask) == 0), "R6 test z",
                    {31'd0, out_z}, {31'd0, ((val & mask) == 0)});
            end
            if (op == 1 || alt == 0)
                chk($countones(out_value ^ val) == 1 || (out_value == val),
                    "R7 one bit", out_value ^ val, mask);
        end

        // test on both bit states of a known word
        issue(1'b1, 1'b0, 1'b1, 2, 0, 0, 12, 32'h0000_0004);
        chk(out_z == 1'b0, "R6 z bit one", {31'd0, out_z}, 0);
        issue(1'b1, 1'b0, 1'b1, 2, 0, 0, 12, 32'hFFFF_FFFB);
        chk(out_z == 1'b1, "R6 z bit zero", {31'd0, out_z}, 1);

        // register selection sweep
        for (int d = 0; d < 16; d++)
        for (int s = 0; s < 16; s++) begin
            issue(1'b1, 1'b1, 1'b0, 0, 0, s, d, 32'h0);
            chk(out_reg == 4'(d ^ s), "R2 register", {28'd0, out_reg}, d ^ s);
        end

        // idle cycle after a set request
        issue(1'b0, 1'b1, 1'b0, 5, 3, 0, 12, 32'h1234_5678);
        chk(!out_valid && !out_we && !out_z_upd, "R10 idle",
            {29'd0, out_valid, out_we, out_z_upd}, 0);
        issue(1'b0, 1'b0, 1'b1, 5, 3, 0, 12, 32'h1234_5678);
        chk(!out_valid && !out_we && !out_z_upd, "R10 idle test",
            {29'd0, out_valid, out_we, out_z_upd}, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule